// File: doc/BRIEF.md
# Banked Lower Memory Window Controller

This block sits between a CPU with a 16-bit address bus and the memories behind it. The address space is split into two halves. The upper half (0x8000 to 0xFFFF) is always ordinary read/write RAM. The lower half (0x0000 to 0x7FFF) is a window that a 3-bit bank register steers to one of several targets. For every bus access the block returns a one-hot chip select, a read enable, a write enable and a physical address inside the selected target. When a read hits an unmapped location, it raises a fill flag so that the data mux drives 0xFF.

The window can point at main RAM slices, video RAM (16 KB, mirrored), or boot ROM (read-only). When an expansion card is fitted, two of the bank codes point at the card instead: one at a mirrored 16 KB card ROM and one at a 32 KB page of card RAM. A 4-bit page register selects that page and is written through an I/O port. Two static configuration inputs give the installed main RAM size and the card size. All mapping is combinational from the registered bank and page values. The only state is those two registers, loaded on a clock edge.

Top module: `memwin_ctrl`

## Requirements
- R1: After reset the bank register holds 7 (boot ROM). A lower-window read then asserts cs bit 2 with phys_addr equal to mem_addr[14:0].
- R2: Any access with mem_addr[15]=1 selects main RAM (cs bit 0) for reads and writes, whatever the bank. phys_addr is 0x8000 + mem_addr[14:0].
- R3: Bank code 0 maps the window to main RAM at phys mem_addr[14:0]. Codes 2..6 without a card, and codes 3, 4 and 6 with a card, map to main RAM slice k=code-2 at phys (k+2)*0x8000 + mem_addr[14:0].
- R4: ram_size_code n (0..5) means 64 KB + n*32 KB of main RAM is installed. A slice k with k >= n is unmapped for both reads and writes.
- R5: Bank code 1 selects video RAM (cs bit 1). phys_addr is mem_addr[13:0], so bit 14 is ignored and the 16 KB appears twice.
- R6: With bank code 7, lower-window reads select boot ROM. Lower-window writes produce no chip select and no write enable.
- R7: card_size 0 means no card, 1 means a 256 KB card and 2 or 3 means a 512 KB card. With a card, code 2 selects card ROM (cs bit 3) at phys mem_addr[13:0], read-only and mirrored.
- R8: With a card, code 5 selects card RAM (cs bit 4) at phys page*0x8000 + mem_addr[14:0].
- R9: An I/O write to any port 0x30..0x3F loads io_wdata[3:0] into the page register. I/O writes to other ports leave it unchanged.
- R10: With a 256 KB card, page values 8..15 leave the card RAM window unmapped.
- R11: A read of an unmapped location asserts fill_en and no chip select. An unmapped write asserts nothing. When mapped, phys_addr carries the target address; when unmapped it is 0.
- R12: The bank and page registers load on the rising edge at which their write strobe is high. The mapping before that edge uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_wr | input | 1 | Bank register write strobe |
| bank_wdata | input | 3 | New bank code |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 4 | Page value carried by the I/O write |
| ram_size_code | input | 3 | Installed main RAM: 64 KB + n*32 KB |
| card_size | input | 2 | 0 none, 1 256 KB, 2/3 512 KB |
| mem_addr | input | 16 | CPU memory address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| cs | output | 5 | One-hot select: main, vram, boot rom, card rom, card ram |
| rd_en | output | 1 | Read enable to the selected target |
| wr_en | output | 1 | Write enable to the selected target |
| phys_addr | output | 19 | Address inside the selected target |
| fill_en | output | 1 | Drive 0xFF on an unmapped read |

## Verification
The hardest case to reach is the card RAM window with a 256 KB card and a page above 7. Reaching it needs three things at once: the card configuration, bank code 5, and a prior I/O write to a port in the 0x30..0x3F range. The stimulus sweeps every combination of card size, RAM size, page value and bank code. It programs the page with varying low port nibbles before loading the bank register. It then probes addresses on both sides of bit 14 and bit 15. Separate sequences write to neighbouring ports that must be ignored, and they check the old mapping during the cycle in which a bank write is pending.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
  localparam int TGT_N = 5;
  typedef enum logic [2:0] {
    TGT_MAIN  = 3'd0,
    TGT_VRAM  = 3'd1,
    TGT_BROM  = 3'd2,
    TGT_CROM  = 3'd3,
    TGT_CRAM  = 3'd4
  } tgt_e;
  localparam logic [2:0] BANK_BOOT = 3'd7;
endpackage

// File: rtl/memwin_regs.sv
module memwin_regs #(
  parameter int BANK_W = 3,
  parameter int PAGE_W = 4,
  parameter logic [7:0] PAGE_PORT = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr,
  input  logic [BANK_W-1:0] bank_wdata,
  input  logic              io_wr,
  input  logic [7:0]        io_addr,
  input  logic [PAGE_W-1:0] io_wdata,
  output logic [BANK_W-1:0] bank_q,
  output logic [PAGE_W-1:0] page_q
);
  logic port_hit;
  // the low nibble of the port address is ignored: 16 mirrored ports
  assign port_hit = io_wr && ((io_addr | 8'h0F) == (PAGE_PORT | 8'h0F));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= BANK_W'(memwin_pkg::BANK_BOOT);
      page_q <= '0;
    end else begin
      if (bank_wr) bank_q <= bank_wdata;
      if (port_hit) page_q <= io_wdata;
    end
  end

  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n) bank_wr |=> bank_q == $past(bank_wdata)); // R12
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !bank_wr |=> $stable(bank_q)); // R12
  AST_PAGE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n) (!io_wr || io_addr[7:4] != PAGE_PORT[7:4]) |=> $stable(page_q)); // R9
endmodule

// File: rtl/memwin_decode.sv
module memwin_decode
  import memwin_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int PAGE_W = 4,
  parameter int WIN_AW = 15,
  parameter int MIRROR_AW = 14,
  parameter int PHYS_W = PAGE_W + WIN_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank,
  input  logic [PAGE_W-1:0] page,
  input  logic [2:0]        ram_size_code,
  input  logic [1:0]        card_size,
  input  logic [15:0]       mem_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  output logic [TGT_N-1:0]  cs,
  output logic              rd_en,
  output logic              wr_en,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              fill_en
);
  localparam int SLICE_W = PHYS_W - WIN_AW;

  tgt_e              tgt;
  logic              mapped;
  logic              writable;
  logic [PHYS_W-1:0] map_addr;
  logic              card_on;
  logic              card_small;
  logic [WIN_AW-1:0] woff;
  logic [PHYS_W-1:0] mir_off;

  assign card_on    = card_size != 2'd0;
  assign card_small = card_size == 2'd1;
  assign woff       = mem_addr[WIN_AW-1:0];
  assign mir_off    = PHYS_W'(mem_addr[MIRROR_AW-1:0]);

  function automatic logic [PHYS_W-1:0] slice_addr(input logic [SLICE_W-1:0] idx,
                                                   input logic [WIN_AW-1:0] off);
    return {idx, off};
  endfunction

  always_comb begin
    tgt      = TGT_MAIN;
    mapped   = 1'b1;
    writable = 1'b1;
    map_addr = '0;
    if (mem_addr[15]) begin
      map_addr = slice_addr(SLICE_W'(1), woff);
    end else begin
      case (bank)
        3'd0: map_addr = slice_addr('0, woff);
        3'd1: begin
          tgt      = TGT_VRAM;
          map_addr = mir_off;
        end
        3'd7: begin
          tgt      = TGT_BROM;
          writable = 1'b0;
          map_addr = PHYS_W'(woff);
        end
        3'd2: begin
          if (card_on) begin
            tgt      = TGT_CROM;
            writable = 1'b0;
            map_addr = mir_off;
          end else begin
            mapped   = 3'(bank - 3'd2) < ram_size_code;
            map_addr = slice_addr(SLICE_W'(bank), woff);
          end
        end
        3'd5: begin
          if (card_on) begin
            tgt      = TGT_CRAM;
            mapped   = !(card_small && page[PAGE_W-1]);
            map_addr = slice_addr(SLICE_W'(page), woff);
          end else begin
            mapped   = 3'(bank - 3'd2) < ram_size_code;
            map_addr = slice_addr(SLICE_W'(bank), woff);
          end
        end
        default: begin
          mapped   = 3'(bank - 3'd2) < ram_size_code;
          map_addr = slice_addr(SLICE_W'(bank), woff);
        end
      endcase
    end
  end

  logic access_ok;
  assign access_ok = mapped && (mem_rd || (mem_wr && writable));
  assign rd_en     = mapped && mem_rd;
  assign wr_en     = mapped && writable && mem_wr;
  assign fill_en   = !mapped && mem_rd;
  assign phys_addr = mapped ? map_addr : '0;

  for (genvar g = 0; g < TGT_N; g++) begin : g_cs
    assign cs[g] = access_ok && (tgt == tgt_e'(g));
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs)); // R11
  AST_FILL_NO_CS: assert property (@(posedge clk) disable iff (!rst_n) fill_en |-> (cs == '0 && !rd_en)); // R11
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n) (mem_addr[15] && (mem_rd || mem_wr)) |-> cs == TGT_N'(1)); // R2
  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (!mem_addr[15] && bank == 3'd7) |-> !wr_en); // R6
  AST_CROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) cs[TGT_CROM] |-> !mem_wr); // R7
endmodule

// File: rtl/memwin_ctrl.sv
module memwin_ctrl
  import memwin_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int PAGE_W = 4,
  parameter int WIN_AW = 15,
  parameter int MIRROR_AW = 14,
  parameter logic [7:0] PAGE_PORT = 8'h30,
  parameter int PHYS_W = PAGE_W + WIN_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr,
  input  logic [BANK_W-1:0] bank_wdata,
  input  logic              io_wr,
  input  logic [7:0]        io_addr,
  input  logic [PAGE_W-1:0] io_wdata,
  input  logic [2:0]        ram_size_code,
  input  logic [1:0]        card_size,
  input  logic [15:0]       mem_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  output logic [TGT_N-1:0]  cs,
  output logic              rd_en,
  output logic              wr_en,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              fill_en
);
  logic [BANK_W-1:0] bank_q;
  logic [PAGE_W-1:0] page_q;

  memwin_regs #(.BANK_W(BANK_W), .PAGE_W(PAGE_W), .PAGE_PORT(PAGE_PORT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bank_wr(bank_wr), .bank_wdata(bank_wdata),
    .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .bank_q(bank_q), .page_q(page_q)
  );

  memwin_decode #(.BANK_W(BANK_W), .PAGE_W(PAGE_W), .WIN_AW(WIN_AW),
                  .MIRROR_AW(MIRROR_AW), .PHYS_W(PHYS_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .bank(bank_q), .page(page_q),
    .ram_size_code(ram_size_code), .card_size(card_size),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .cs(cs), .rd_en(rd_en), .wr_en(wr_en),
    .phys_addr(phys_addr), .fill_en(fill_en)
  );
endmodule

// File: tb/memwin_ctrl_tb_top.sv
module memwin_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_wr = 1'b0;
  logic [2:0]  bank_wdata = '0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_addr = '0;
  logic [3:0]  io_wdata = '0;
  logic [2:0]  ram_size_code = '0;
  logic [1:0]  card_size = '0;
  logic [15:0] mem_addr = '0;
  logic        mem_rd = 1'b0;
  logic        mem_wr = 1'b0;
  logic [4:0]  cs;
  logic        rd_en, wr_en, fill_en;
  logic [18:0] phys_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  memwin_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_wdata(bank_wdata),
    .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .ram_size_code(ram_size_code), .card_size(card_size),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .cs(cs), .rd_en(rd_en), .wr_en(wr_en), .phys_addr(phys_addr), .fill_en(fill_en)
  );

  // {cs[4:0], rd_en, wr_en, fill_en, phys[18:0]}
  function automatic logic [26:0] model(input int code, input int rsz, input int card,
                                        input int page, input int a, input bit rd, input bit wr);
    int tgt = 0; bit mapped = 1; bit wable = 1; int ph = 0;
    logic [4:0] c;
    if (a >= 32768) ph = 32768 + (a % 32768);
    else if (code == 0) ph = a;
    else if (code == 1) begin tgt = 1; ph = a % 16384; end
    else if (code == 7) begin tgt = 2; wable = 0; ph = a; end
    else if (code == 2 && card != 0) begin tgt = 3; wable = 0; ph = a % 16384; end
    else if (code == 5 && card != 0) begin
      tgt = 4; mapped = !(card == 1 && page > 7); ph = page * 32768 + a;
    end else begin
      mapped = (code - 2) < rsz; ph = (code) * 32768 + a;
    end
    if (!mapped) ph = 0;
    c = (mapped && (rd || (wr && wable))) ? 5'(1 << tgt) : 5'd0;
    return {c, mapped && rd, mapped && wable && wr, !mapped && rd, 19'(ph)};
  endfunction

  task automatic chk(input string tag, input logic [26:0] exp);
    logic [26:0] act;
    act = {cs, rd_en, wr_en, fill_en, phys_addr};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: addr=%h act=%h exp=%h", tag, mem_addr, act, exp);
    end
  endtask

  task automatic set_bank(input int code);
    @(negedge clk); bank_wr = 1'b1; bank_wdata = 3'(code);
    @(negedge clk); bank_wr = 1'b0;
  endtask

  task automatic io_write(input logic [7:0] port, input logic [3:0] d);
    @(negedge clk); io_wr = 1'b1; io_addr = port; io_wdata = d;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic access(input int a, input bit rd, input bit wr);
    mem_addr = 16'(a); mem_rd = rd; mem_wr = wr; #1;
  endtask

  function automatic string tag_of(input int code, input int rsz, input int card,
                                   input int page, input int a);
    if (a >= 32768) return "R2";
    if (code == 0) return "R3";
    if (code == 1) return "R5";
    if (code == 7) return "R6";
    if (code == 2 && card != 0) return "R7";
    if (code == 5 && card != 0) return (card == 1 && page > 7) ? "R10" : "R8";
    if ((code - 2) >= rsz) return "R4";
    return "R3";
  endfunction

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          failures++;
          $display("FAIL watchdog expired");
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none
  end

  initial begin
    int addrs[5];
    int pages[4];
    addrs = '{0, 16'h4ABC, 16'h7FFF, 16'h8000, 16'hC123};
    pages = '{0, 7, 8, 15};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: boot ROM selected after reset
    access(0, 1, 0);       chk("R1", model(7, 0, 0, 0, 0, 1, 0));
    access(16'h5A5A, 1, 0); chk("R1", model(7, 0, 0, 0, 16'h5A5A, 1, 0));
    access(16'h1000, 0, 1); chk("R6", model(7, 0, 0, 0, 16'h1000, 0, 1));

    for (int card = 0; card < 3; card++)
      for (int rsz = 0; rsz < 6; rsz++)
        for (int pi = 0; pi < 4; pi++) begin
          card_size = 2'(card); ram_size_code = 3'(rsz);
          io_write(8'h30 | 8'((pi * 5 + rsz) % 16), 4'(pages[pi]));  // R9 mirrored ports
          for (int code = 0; code < 8; code++) begin
            set_bank(code);
            for (int ai = 0; ai < 5; ai++)
              for (int op = 0; op < 2; op++) begin
                access(addrs[ai], op == 0, op == 1);
                chk(tag_of(code, rsz, card, pages[pi], addrs[ai]),
                    model(code, rsz, card, pages[pi], addrs[ai], op == 0, op == 1));
              end
          end
        end

    // R9: neighbouring ports do not touch the page register
    card_size = 2'd2; ram_size_code = 3'd5;
    io_write(8'h3F, 4'd6);
    set_bank(5);
    io_write(8'h2F, 4'd9);
    io_write(8'h40, 4'd3);
    access(16'h0123, 1, 0); chk("R9", model(5, 5, 2, 6, 16'h0123, 1, 0));
    io_write(8'h35, 4'd11);
    access(16'h0123, 1, 0); chk("R9", model(5, 5, 2, 11, 16'h0123, 1, 0));

    // R11: unmapped read fills, unmapped write does nothing
    card_size = 2'd0; ram_size_code = 3'd0;
    set_bank(6);
    access(16'h2222, 1, 0); chk("R11", {5'd0, 1'b0, 1'b0, 1'b1, 19'd0});
    access(16'h2222, 0, 1); chk("R11", {5'd0, 1'b0, 1'b0, 1'b0, 19'd0});

    // R12: pending bank write does not change mapping before the edge
    set_bank(7);
    @(negedge clk);
    bank_wr = 1'b1; bank_wdata = 3'd1;
    access(16'h4010, 1, 0); chk("R12", model(7, 0, 0, 0, 16'h4010, 1, 0));
    @(posedge clk); #1;
    bank_wr = 1'b0;
    chk("R12", model(1, 0, 0, 0, 16'h4010, 1, 0));
    // R12: page register timing
    card_size = 2'd2; set_bank(5);
    access(16'h0040, 1, 0);
    @(negedge clk);
    io_wr = 1'b1; io_addr = 8'h30; io_wdata = 4'd13; #1;
    chk("R12", model(5, 0, 2, 11, 16'h0040, 1, 0));
    @(posedge clk); #1;
    io_wr = 1'b0;
    chk("R12", model(5, 0, 2, 13, 16'h0040, 1, 0));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule